// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block is the control and status register next to a single-precision arithmetic datapath. It keeps six sticky exception flags, six matching mask bits and two mode bits in one 16-bit register. Each operation the datapath issues arrives as a valid strobe with an operation class, the two raw operands and four event pulses: invalid, denormal operand, divide-by-zero and overflow. The block filters these pulses by operation class and merges them into the flags.

The block also inspects the raw operands. It finds denormal operands, and for divides it finds a zero divisor under a finite non-zero dividend. When the denormals-as-zero mode bit is set, it hands the datapath operands in which every denormal is replaced by a zero of the same sign, and it bases its own divide checks on those replaced values.

Software reads the register at `csr_o` and replaces it through a one-cycle write strobe. `exc_req_o` goes high whenever some flag is set while its mask bit is clear.

Top module: `fpx_status_reg`

## Requirements
- R1: After reset the register reads 0x1F80, with every flag clear and all six mask bits (7 to 12) set, and `exc_req_o` is low.
- R2: When `wr_en_i` is high at a clock edge, the register takes `wr_data_i` on all 16 bits, and `csr_o` shows the new value after that edge.
- R3: Flags at bits 0 to 5 are sticky. Once set they stay set through later operations and clear only through a software write of 0 to that bit.
- R4: A valid operation sets bit 1 (denormal) when a used operand has exponent 0 and a non-zero fraction and bit 6 (denormals-as-zero) is clear. The classes add, subtract, multiply, divide and other use both operands. The conversion classes and the reciprocal-estimate class use only `opa_i`. An `evt_denorm_i` pulse also sets bit 1.
- R5: A divide (class 3) sets bit 2 when the dividend is finite and non-zero and the effective divisor is zero; with bit 6 set, a denormal divisor counts as zero. An `evt_div0_i` pulse sets bit 2 only for class 3.
- R6: A divide whose effective dividend and effective divisor are both zero sets bit 0 (invalid) and not bit 2.
- R7: An `evt_ovf_i` pulse sets bit 3 only for add (0), subtract (1), multiply (2), divide (3) and narrowing convert (5). For other classes the pulse is ignored.
- R8: The integer-convert class (4) never sets bit 1. The reciprocal-estimate class (6) sets no flag at all, whatever its pulses and operands.
- R9: With bit 6 set, `opa_eff_o` and `opb_eff_o` carry each denormal operand as a zero with its sign kept. Every other operand passes through unchanged.
- R10: Bit 15 (flush-to-zero mode) has no effect on the denormal, divide-by-zero or overflow flags.
- R11: `exc_req_o` is high exactly when some flag bit k (0 to 5) is set while mask bit k+7 is clear.
- R12: A write in the same cycle as an operation stores the written value ORed with the flags that the operation raises.
- R13: While `op_valid_i` is low, operands and pulses leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 16 | Software write value |
| csr_o | output | 16 | Current register value |
| op_valid_i | input | 1 | An operation completes this cycle |
| op_class_i | input | 3 | Operation class: 0 add, 1 sub, 2 mul, 3 div, 4 int convert, 5 narrowing convert, 6 reciprocal estimate, 7 other |
| opa_i | input | 32 | Raw first operand (dividend for divide) |
| opb_i | input | 32 | Raw second operand (divisor for divide) |
| evt_invalid_i | input | 1 | Datapath invalid-operation pulse |
| evt_denorm_i | input | 1 | Datapath denormal-operand pulse |
| evt_div0_i | input | 1 | Datapath divide-by-zero pulse |
| evt_ovf_i | input | 1 | Datapath overflow pulse |
| opa_eff_o | output | 32 | First operand after denormals-as-zero replacement |
| opb_eff_o | output | 32 | Second operand after denormals-as-zero replacement |
| exc_req_o | output | 1 | Unmasked exception request |

## Verification
Divides are run with four kinds of dividend and divisor: finite over zero, zero over zero, infinity over zero, and a denormal divisor. Each divisor pattern is tried with denormals-as-zero both clear and set, which shows whether the divide check uses the raw or the replaced operands and whether it picks the invalid flag or the divide-by-zero flag. The same event pulses and denormal operands are sent under each operation class, which shows which class blocks which flag. Writes that coincide with events, and mask patterns that flip the request, show that write and event are merged correctly and that the request follows each flag and mask pair.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int CSR_W    = 16;
  localparam int NFLAG    = 6;
  localparam int NEVT     = 4;
  localparam int MASK_LSB = 7;
  localparam int EXP_W    = 8;
  localparam int MAN_W    = 23;
  localparam int FP_W     = 1 + EXP_W + MAN_W;

  localparam int FLG_INV  = 0;
  localparam int FLG_DEN  = 1;
  localparam int FLG_DZ   = 2;
  localparam int FLG_OVF  = 3;
  localparam int DAZ_BIT  = 6;
  localparam int FTZ_BIT  = 15;

  localparam logic [CSR_W-1:0] CSR_RST = 16'h1F80;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_MUL    = 3'd2,
    OP_DIV    = 3'd3,
    OP_CVTI   = 3'd4,
    OP_CVTN   = 3'd5,
    OP_RCP    = 3'd6,
    OP_MISC   = 3'd7
  } op_class_e;

  typedef struct packed {
    logic is_zero;
    logic is_den;
    logic is_finite;
  } opnd_info_t;
endpackage

// File: rtl/fpx_operand_classify.sv
module fpx_operand_classify
  import fpx_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] opnd_i,
  input  logic           daz_i,
  output opnd_info_t     info_o,
  output logic [EW+MW:0] eff_o
);
  localparam int W = EW + MW + 1;

  logic          sign;
  logic [EW-1:0] expo;
  logic [MW-1:0] frac;

  assign sign = opnd_i[W-1];
  assign expo = opnd_i[W-2:MW];
  assign frac = opnd_i[MW-1:0];

  assign info_o.is_zero   = (expo == '0) && (frac == '0);
  assign info_o.is_den    = (expo == '0) && (frac != '0);
  assign info_o.is_finite = (expo != '1);

  // Replace a denormal by a zero that keeps the sign
  assign eff_o = (daz_i && info_o.is_den) ? {sign, {(W-1){1'b0}}} : opnd_i;
endmodule

// File: rtl/fpx_event_gen.sv
module fpx_event_gen
  import fpx_pkg::*;
(
  input  logic            valid_i,
  input  op_class_e       cls_i,
  input  logic            daz_i,
  input  opnd_info_t      a_i,
  input  opnd_info_t      b_i,
  input  logic            evt_inv_i,
  input  logic            evt_den_i,
  input  logic            evt_dz_i,
  input  logic            evt_ovf_i,
  output logic [NEVT-1:0] set_o
);
  logic unary, is_div, allow_any, allow_den, allow_ovf;
  logic den_seen, det_den, a_zero_eff, b_zero_eff, det_dz, det_inv;

  always_comb begin
    unary     = (cls_i == OP_CVTI) || (cls_i == OP_CVTN) || (cls_i == OP_RCP);
    is_div    = (cls_i == OP_DIV);
    allow_any = (cls_i != OP_RCP);
    allow_den = allow_any && (cls_i != OP_CVTI);
    allow_ovf = (cls_i == OP_ADD) || (cls_i == OP_SUB) || (cls_i == OP_MUL) ||
                (cls_i == OP_DIV) || (cls_i == OP_CVTN);

    den_seen  = a_i.is_den || (!unary && b_i.is_den);
    det_den   = !daz_i && den_seen;

    a_zero_eff = a_i.is_zero || (daz_i && a_i.is_den);
    b_zero_eff = b_i.is_zero || (daz_i && b_i.is_den);
    det_dz     = is_div && b_zero_eff && !a_zero_eff && a_i.is_finite;
    det_inv    = is_div && a_zero_eff && b_zero_eff;

    set_o          = '0;
    set_o[FLG_INV] = valid_i && allow_any && (evt_inv_i || det_inv);
    set_o[FLG_DEN] = valid_i && allow_den && (evt_den_i || det_den);
    set_o[FLG_DZ]  = valid_i && is_div    && (evt_dz_i  || det_dz);
    set_o[FLG_OVF] = valid_i && allow_ovf && evt_ovf_i;
  end
endmodule

// File: rtl/fpx_csr_core.sv
module fpx_csr_core
  import fpx_pkg::*;
#(
  parameter int                 W     = CSR_W,
  parameter int                 NF    = NFLAG,
  parameter int                 NE    = NEVT,
  parameter int                 M_LSB = MASK_LSB,
  parameter logic [CSR_W-1:0]   RST   = CSR_RST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [NE-1:0] set_i,
  output logic [W-1:0]  csr_o,
  output logic          req_o
);
  logic [W-1:0]  csr_q, base, set_ext;
  logic [NF-1:0] pend;

  always_comb begin
    set_ext       = '0;
    set_ext[NE-1:0] = set_i;
    base          = wr_en_i ? wr_data_i : csr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= RST;
    else         csr_q <= base | set_ext;
  end

  for (genvar k = 0; k < NF; k++) begin : g_pend
    assign pend[k] = csr_q[k] && !csr_q[M_LSB+k];
  end

  assign csr_o = csr_q;
  assign req_o = |pend;
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CSR_W-1:0]  wr_data_i,
  output logic [CSR_W-1:0]  csr_o,
  input  logic              op_valid_i,
  input  logic [2:0]        op_class_i,
  input  logic [FP_W-1:0]   opa_i,
  input  logic [FP_W-1:0]   opb_i,
  input  logic              evt_invalid_i,
  input  logic              evt_denorm_i,
  input  logic              evt_div0_i,
  input  logic              evt_ovf_i,
  output logic [FP_W-1:0]   opa_eff_o,
  output logic [FP_W-1:0]   opb_eff_o,
  output logic              exc_req_o
);
  localparam int NOP = 2;

  logic [NOP-1:0][FP_W-1:0] raw, eff;
  opnd_info_t [NOP-1:0]     info;
  logic [NEVT-1:0]          set;
  logic                     daz;

  assign daz    = csr_o[DAZ_BIT];
  assign raw[0] = opa_i;
  assign raw[1] = opb_i;

  for (genvar i = 0; i < NOP; i++) begin : g_opnd
    fpx_operand_classify #(.EW(EXP_W), .MW(MAN_W)) u_cls (
      .opnd_i (raw[i]),
      .daz_i  (daz),
      .info_o (info[i]),
      .eff_o  (eff[i])
    );
  end

  assign opa_eff_o = eff[0];
  assign opb_eff_o = eff[1];

  fpx_event_gen u_evt (
    .valid_i   (op_valid_i),
    .cls_i     (op_class_e'(op_class_i)),
    .daz_i     (daz),
    .a_i       (info[0]),
    .b_i       (info[1]),
    .evt_inv_i (evt_invalid_i),
    .evt_den_i (evt_denorm_i),
    .evt_dz_i  (evt_div0_i),
    .evt_ovf_i (evt_ovf_i),
    .set_o     (set)
  );

  fpx_csr_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .set_i     (set),
    .csr_o     (csr_o),
    .req_o     (exc_req_o)
  );
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk
  import fpx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CSR_W-1:0] csr_o,
  input logic             op_valid_i,
  input logic [2:0]       op_class_i,
  input logic [FP_W-1:0]  opa_i,
  input logic [FP_W-1:0]  opb_i,
  input logic [FP_W-1:0]  opa_eff_o,
  input logic             exc_req_o
);
  logic quiet_cls;
  assign quiet_cls = (op_class_i == 3'd4) || (op_class_i == 3'd6) || (op_class_i == 3'd7);

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((csr_o[5:0] & $past(csr_o[5:0])) == $past(csr_o[5:0])));

  p_idle_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !wr_en_i) |=> (csr_o == $past(csr_o)));

  p_rcp_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i == 3'd6 && !wr_en_i) |=> (csr_o == $past(csr_o)));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && quiet_cls && !wr_en_i && !csr_o[FLG_OVF]) |=> !csr_o[FLG_OVF]);

  p_div0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_class_i == 3'd3 && !wr_en_i && opb_i[30:0] == '0 &&
     opa_i[30:0] != '0 && opa_i[30:23] != 8'hFF && opa_i[30:23] != 8'h00) |=> csr_o[FLG_DZ]);

  p_no_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o[5:0] == '0 || csr_o[12:7] == '1) |-> !exc_req_o);

  p_daz_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o[DAZ_BIT] && opa_i[30:23] == '0) |-> (opa_eff_o == {opa_i[31], 31'b0}));
endmodule

bind fpx_status_reg fpx_status_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .csr_o      (csr_o),
  .op_valid_i (op_valid_i),
  .op_class_i (op_class_i),
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .opa_eff_o  (opa_eff_o),
  .exc_req_o  (exc_req_o)
);

// File: tb/sim_fpx_status_reg.sv
`timescale 1ns/1ps
module sim_fpx_status_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] csr_o;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_class_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        evt_invalid_i = 1'b0, evt_denorm_i = 1'b0, evt_div0_i = 1'b0, evt_ovf_i = 1'b0;
  logic [31:0] opa_eff_o, opb_eff_o;
  logic        exc_req_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [2:0] C_ADD = 3'd0, C_MUL = 3'd2, C_DIV = 3'd3, C_CVTI = 3'd4,
                         C_CVTN = 3'd5, C_RCP = 3'd6, C_MISC = 3'd7;
  localparam logic [31:0] ONE = 32'h3F80_0000, ZERO = 32'h0, INF = 32'h7F80_0000,
                          DEN = 32'h0000_0001, NDEN = 32'h8000_0010;

  always #2.5 clk_i = ~clk_i;

  fpx_status_reg u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  // pulses: {inv, den, dz, ovf}
  task automatic op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                    input logic [3:0] p, input logic v = 1'b1,
                    input logic w = 1'b0, input logic [15:0] d = '0);
    @(negedge clk_i);
    op_valid_i = v; op_class_i = c; opa_i = a; opb_i = b;
    {evt_invalid_i, evt_denorm_i, evt_div0_i, evt_ovf_i} = p;
    wr_en_i = w; wr_data_i = d;
    @(negedge clk_i);
    op_valid_i = 1'b0; wr_en_i = 1'b0;
    {evt_invalid_i, evt_denorm_i, evt_div0_i, evt_ovf_i} = '0;
    opa_i = ONE; opb_i = ONE;
  endtask

  task automatic t_reset;
    chk("R1 reset value", 32'(csr_o), 32'h1F80);
    chk("R1 reset request", 32'(exc_req_o), 0);
  endtask

  task automatic t_write;
    wr(16'h0000); chk("R2 write zero", 32'(csr_o), 32'h0000);
    wr(16'h0001); chk("R11 unmasked invalid request", 32'(exc_req_o), 1);
    wr(16'h0081); chk("R11 masked invalid no request", 32'(exc_req_o), 0);
    wr(16'h6A55); chk("R2 write pattern", 32'(csr_o), 32'h6A55);
    wr(16'h1F80);
  endtask

  task automatic t_denorm;
    op(C_ADD, ONE, DEN, 4'b0000);
    chk("R4 denormal second operand", 32'(csr_o), 32'h1F82);
    op(C_ADD, ONE, ONE, 4'b0000);
    chk("R3 flag stays set", 32'(csr_o), 32'h1F82);
    wr(16'h1F80); chk("R3 cleared by write", 32'(csr_o), 32'h1F80);
    op(C_CVTN, ONE, DEN, 4'b0000);
    chk("R4 unary ignores second operand", 32'(csr_o), 32'h1F80);
    op(C_CVTN, NDEN, ONE, 4'b0000);
    chk("R4 narrowing convert denormal", 32'(csr_o), 32'h1F82);
    wr(16'h1F80);
    op(C_MUL, ONE, ONE, 4'b0100);
    chk("R4 denormal pulse", 32'(csr_o), 32'h1F82);
    wr(16'h1F80);
  endtask

  task automatic t_daz;
    wr(16'h1FC0);
    @(negedge clk_i); opa_i = NDEN; opb_i = DEN; #1;
    chk("R9 negative denormal to -0", opa_eff_o, 32'h8000_0000);
    chk("R9 positive denormal to +0", opb_eff_o, 32'h0000_0000);
    opa_i = ONE; #1;
    chk("R9 normal passes", opa_eff_o, ONE);
    op(C_ADD, DEN, NDEN, 4'b0000);
    chk("R4 DAZ suppresses operand detection", 32'(csr_o), 32'h1FC0);
    wr(16'h1F80);
  endtask

  task automatic t_div;
    op(C_DIV, ONE, ZERO, 4'b0000);
    chk("R5 finite over zero", 32'(csr_o), 32'h1F84);
    wr(16'h1F80);
    op(C_DIV, ZERO, 32'h8000_0000, 4'b0000);
    chk("R6 zero over zero", 32'(csr_o), 32'h1F81);
    wr(16'h1F80);
    op(C_DIV, INF, ZERO, 4'b0000);
    chk("R5 infinity over zero quiet", 32'(csr_o), 32'h1F80);
    op(C_DIV, ONE, DEN, 4'b0000);
    chk("R5 raw denormal divisor", 32'(csr_o), 32'h1F82);
    wr(16'h1FC0);
    op(C_DIV, ONE, DEN, 4'b0000);
    chk("R5 DAZ divisor counts as zero", 32'(csr_o), 32'h1FC4);
    wr(16'h1FC0);
    op(C_DIV, DEN, ZERO, 4'b0000);
    chk("R6 DAZ dividend zero over zero", 32'(csr_o), 32'h1FC1);
    wr(16'h1F80);
    op(C_MUL, ONE, ONE, 4'b0010);
    chk("R5 div0 pulse ignored outside divide", 32'(csr_o), 32'h1F80);
  endtask

  task automatic t_class;
    op(C_MISC, ONE, ONE, 4'b0001);
    chk("R7 overflow ignored for other class", 32'(csr_o), 32'h1F80);
    op(C_CVTI, ONE, ONE, 4'b0001);
    chk("R7 overflow ignored for int convert", 32'(csr_o), 32'h1F80);
    op(C_CVTN, ONE, ONE, 4'b0001);
    chk("R7 overflow on narrowing convert", 32'(csr_o), 32'h1F88);
    wr(16'h1F80);
    op(C_CVTI, DEN, DEN, 4'b0100);
    chk("R8 int convert no denormal", 32'(csr_o), 32'h1F80);
    op(C_RCP, DEN, ZERO, 4'b1111);
    chk("R8 reciprocal estimate raises nothing", 32'(csr_o), 32'h1F80);
  endtask

  task automatic t_ftz;
    wr(16'h9F80);
    op(C_DIV, ONE, ZERO, 4'b0001);
    chk("R10 flush mode keeps div0 and overflow", 32'(csr_o), 32'h9F8C);
    op(C_ADD, DEN, ONE, 4'b0000);
    chk("R10 flush mode keeps denormal", 32'(csr_o), 32'h9F8E);
    wr(16'h1F80);
  endtask

  task automatic t_idle;
    op(C_DIV, DEN, ZERO, 4'b1111, 1'b0);
    chk("R13 idle leaves register", 32'(csr_o), 32'h1F80);
  endtask

  task automatic t_merge;
    op(C_ADD, ONE, ONE, 4'b0001, 1'b1, 1'b1, 16'h0000);
    chk("R12 write merged with event", 32'(csr_o), 32'h0008);
    chk("R11 unmasked overflow request", 32'(exc_req_o), 1);
    wr(16'h0408);
    chk("R11 mask restored drops request", 32'(exc_req_o), 0);
    wr(16'h1F80);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    opa_i = ONE; opb_i = ONE;
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_write;
    t_denorm;
    t_daz;
    t_div;
    t_class;
    t_ftz;
    t_idle;
    t_merge;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule